// File: doc/BRIEF.md
# Synchronous SRAM Access Controller

This block models, cycle by cycle, the control path of a pipelined synchronous SRAM with a small word array. All control inputs are sampled on the rising clock edge:

- two address strobes, one driven by a processor and one by a memory controller;
- three chip selects;
- an address-advance input;
- a write-all input, a lane-write enable and one lane select per byte lane.

The block works out from these inputs whether a read, a write or a deselect begins on each edge. It merges byte lanes into the array and registers read data one edge after the address is captured. It decides when the data outputs may be driven. Output enable acts at once, with no clock, on the drive-enable output.

The two write paths have different latencies. A processor-strobe access always launches a read on its first edge. The write controls are looked at only on the following edge, which may write into the captured address. A controller-strobe write completes on the same edge at the presented address.

After the block has been deselected, the first two cycles after a new selection keep the outputs dark. A registered deselect turns them off on that edge.

Top module: `ssr_ctl`

## Requirements
- R1: Read start. A read starts when an active strobe is seen, all chip selects are active (`sel0_n` low, `sel1` high, `sel2_n` low) and both `wr_all_n` and `wr_lane_en_n` are high. The address is captured on that edge, and the word at that address is on `rd_data` after the next edge.
- R2: Processor-strobe gating. While `sel0_n` is high, `host_strb_n` has no effect: no read is launched, no deselect happens, and `rd_data` and `rd_drive` keep their values.
- R3: Processor-strobe access. On the strobe edge the write controls and `step_n` are ignored and a read of the address is launched. On the next edge, an active write-control combination writes `wdata` into the captured address. A read launched on the strobe edge returns the old word.
- R4: Controller-strobe write. With `ctrl_strb_n` low, the processor strobe inactive, the chips selected and an active write combination, the write lands at `addr` on that same edge. No read is launched and `rd_data` is unchanged.
- R5: `wr_all_n` low writes every lane, whatever `wr_lane_en_n` and `lane_sel_n` are.
- R6: With `wr_all_n` high and `wr_lane_en_n` low, lane i is written only when `lane_sel_n[i]` is low. Lane i is bits `[8*i+7:8*i]` when `LANE_W` is 8.
- R7: Reads issued on consecutive edges each return their own word, one per cycle.
- R8: After a start that selects the block from the deselected state, `rd_drive` stays low for the two cycles that follow that edge.
- R9: An active strobe seen with the chip selects not all active is a deselect. `rd_drive` is low right after that edge.
- R10: `out_en_n` high forces `rd_drive` low with no clock edge needed.
- R11: Address advance. On an edge with no strobe, with no processor write pending and with the block selected, `step_n` low adds one to the captured address, wrapping at the top, and reads that word.
- R12: After reset the block is deselected and `rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| host_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| sel0_n | input | 1 | Chip select 0, active low; also gates the processor strobe |
| sel1 | input | 1 | Chip select 1, active high |
| sel2_n | input | 1 | Chip select 2, active low |
| step_n | input | 1 | Address advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| rd_data | output | LANES*LANE_W | Registered read word |
| rd_drive | output | 1 | High when the data outputs are driven |

## Verification
The assertions assume that a processor-strobe access never shares its second edge with a controller write to the same address. They also assume that every input is steady around the rising edge. The directed tasks keep to this: every input change happens on the falling edge, and pending processor writes and controller writes always target different words. The output-enable property assumes `out_en_n` changes only between edges, and the bench flips it mid-cycle, away from any edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef struct packed {
      logic sel_start;
      logic host_start;
      logic ctrl_wr;
      logic launch_rd;
      logic desel;
   } ssr_cmd_t;
endpackage

// File: rtl/ssr_lane_mask.sv
module ssr_lane_mask #(
   parameter int LANES = 2
) (
   input  logic             wr_all_n,
   input  logic             wr_lane_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] mask
);
   if (LANES < 1) begin : g_bad
      $error("ssr_lane_mask: LANES must be at least 1");
   end
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // write-all overrides the per-lane selects
      assign mask[i] = !wr_all_n || (!wr_lane_en_n && !lane_sel_n[i]);
   end
endmodule

// File: rtl/ssr_decode.sv
module ssr_decode
   import ssr_pkg::*;
(
   input  logic     host_strb_n,
   input  logic     ctrl_strb_n,
   input  logic     sel0_n,
   input  logic     sel1,
   input  logic     sel2_n,
   input  logic     wr_all_n,
   input  logic     wr_lane_en_n,
   input  logic     lane_any,
   output ssr_cmd_t cmd
);
   logic sel_ok, host_act, any_strb, ctrl_start;

   always_comb begin
      sel_ok         = !sel0_n && sel1 && !sel2_n;
      host_act       = !host_strb_n && !sel0_n;
      any_strb       = host_act || !ctrl_strb_n;
      ctrl_start     = !ctrl_strb_n && !host_act && sel_ok;
      cmd.desel      = any_strb && !sel_ok;
      cmd.host_start = host_act && sel_ok;
      cmd.sel_start  = cmd.host_start || ctrl_start;
      cmd.ctrl_wr    = ctrl_start && lane_any;
      cmd.launch_rd  = cmd.host_start || (ctrl_start && wr_all_n && wr_lane_en_n);
   end
endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage #(
   parameter int HUSH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_start,
   input  logic desel,
   input  logic rd_done,
   input  logic out_en_n,
   output logic act,
   output logic rd_drive
);
   if (HUSH != 2) begin : g_bad
      $error("ssr_out_stage: the reselect hush is fixed at two cycles");
   end

   logic wake_q, armed_q, dvld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b0;
         wake_q  <= 1'b0;
         armed_q <= 1'b0;
         dvld_q  <= 1'b0;
      end else if (desel) begin
         act     <= 1'b0;
         wake_q  <= 1'b0;
         armed_q <= 1'b0;
         dvld_q  <= 1'b0;
      end else begin
         if (sel_start) act <= 1'b1;
         wake_q  <= act;
         armed_q <= wake_q;
         dvld_q  <= dvld_q || rd_done;
      end
   end

   assign rd_drive = armed_q && dvld_q && !out_en_n;

   AST_FIRST_HUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_start && !desel && !act) |=> !rd_drive ##1 !rd_drive); // R8
endmodule

// File: rtl/ssr_ctl.sv
module ssr_ctl
   import ssr_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    host_strb_n,
   input  logic                    ctrl_strb_n,
   input  logic                    sel0_n,
   input  logic                    sel1,
   input  logic                    sel2_n,
   input  logic                    step_n,
   input  logic                    wr_all_n,
   input  logic                    wr_lane_en_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic                    out_en_n,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic                    rd_drive
);
   localparam int DATA_W = LANES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   if (LANES < 1 || LANE_W < 1 || ADDR_W < 1 || ADDR_W > 10) begin : g_bad
      $error("ssr_ctl: parameter out of range");
   end

   ssr_cmd_t           cmd;
   logic [LANES-1:0]   wmask;
   logic               act, adv, host_pend_q, rd_pend_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  rdata_q;
   logic [DATA_W-1:0]  mem [DEPTH];

   ssr_lane_mask #(.LANES(LANES)) i_mask (
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
      .lane_sel_n(lane_sel_n), .mask(wmask));

   ssr_decode i_dec (
      .host_strb_n(host_strb_n), .ctrl_strb_n(ctrl_strb_n),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
      .lane_any(|wmask), .cmd(cmd));

   ssr_out_stage #(.HUSH(2)) i_out (
      .clk(clk), .rst_n(rst_n), .sel_start(cmd.sel_start), .desel(cmd.desel),
      .rd_done(rd_pend_q), .out_en_n(out_en_n), .act(act), .rd_drive(rd_drive));

   // advance only on quiet edges of a selected block
   assign adv = !step_n && act && !host_pend_q && !cmd.sel_start && !cmd.desel
                && ctrl_strb_n && (host_strb_n || sel0_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_pend_q <= 1'b0;
         rd_pend_q   <= 1'b0;
         addr_q      <= '0;
         rdata_q     <= '0;
      end else begin
         host_pend_q <= cmd.host_start;
         rd_pend_q   <= cmd.launch_rd || adv;
         if (cmd.sel_start) addr_q <= addr;
         else if (adv)      addr_q <= addr_q + 1'b1;
         if (rd_pend_q)     rdata_q <= mem[addr_q];
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (host_pend_q && wmask[i])
            mem[addr_q][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
         if (cmd.ctrl_wr && wmask[i])
            mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
   end

   assign rd_data = rdata_q;

   AST_DESEL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.desel |=> !rd_drive); // R9
   AST_OE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rd_drive); // R10
   AST_HOST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel0_n && ctrl_strb_n && step_n && !rd_pend_q) |=> $stable(rd_data)); // R2
   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.ctrl_wr && !wr_all_n && !host_pend_q) |=> mem[$past(addr)] == $past(wdata)); // R4
   AST_HOST_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.host_start && !host_pend_q) |=> mem[$past(addr)] == $past(mem[addr])); // R3
endmodule

// File: tb/test_ssr_ctl.sv
`timescale 1ns/1ps
module test_ssr_ctl;
   localparam int LANES = 2, LANE_W = 8, ADDR_W = 4;
   localparam int DW = LANES * LANE_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [ADDR_W-1:0] addr;
   logic [DW-1:0] wdata, rd_data;
   logic host_strb_n, ctrl_strb_n, sel0_n, sel1, sel2_n, step_n;
   logic wr_all_n, wr_lane_en_n, out_en_n, rd_drive;
   logic [LANES-1:0] lane_sel_n;
   logic [DW-1:0] ref_mem [1<<ADDR_W];
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   ssr_ctl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) i_ssr_ctl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .host_strb_n(host_strb_n), .ctrl_strb_n(ctrl_strb_n), .sel0_n(sel0_n),
      .sel1(sel1), .sel2_n(sel2_n), .step_n(step_n), .wr_all_n(wr_all_n),
      .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
      .rd_data(rd_data), .rd_drive(rd_drive));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic edge_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      host_strb_n = 1; ctrl_strb_n = 1; sel0_n = 0; sel1 = 1; sel2_n = 0;
      step_n = 1; wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = '1;
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                           input logic all_n, input logic len_n,
                                           input logic [LANES-1:0] ls_n);
      logic [DW-1:0] r = old;
      for (int i = 0; i < LANES; i++)
         if (!all_n || (!len_n && !ls_n[i])) r[i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
      return r;
   endfunction

   task automatic ctrl_read(input logic [ADDR_W-1:0] a);
      idle(); ctrl_strb_n = 0; addr = a;
      edge_step();
      idle();
   endtask

   task automatic ctrl_write(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                             input logic all_n, input logic len_n, input logic [LANES-1:0] ls_n);
      idle(); ctrl_strb_n = 0; addr = a; wdata = d;
      wr_all_n = all_n; wr_lane_en_n = len_n; lane_sel_n = ls_n;
      ref_mem[a] = merge(ref_mem[a], d, all_n, len_n, ls_n);
      edge_step();
      idle();
   endtask

   task automatic host_access(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                              input logic all_n, input logic len_n, input logic [LANES-1:0] ls_n,
                              output logic [DW-1:0] first_rd);
      logic [DW-1:0] old = ref_mem[a];
      idle(); host_strb_n = 0; addr = a; wr_all_n = 0; wdata = ~d; step_n = 0;
      edge_step();
      idle(); wdata = d; wr_all_n = all_n; wr_lane_en_n = len_n; lane_sel_n = ls_n;
      ref_mem[a] = merge(ref_mem[a], d, all_n, len_n, ls_n);
      edge_step();
      first_rd = rd_data;
      chk("R3 strobe-edge read returns old word", first_rd, old);
      idle();
   endtask

   task automatic read_back(input string req, input logic [ADDR_W-1:0] a);
      ctrl_read(a);
      edge_step();
      chk(req, rd_data, ref_mem[a]);
   endtask

   task automatic t_reset();
      chk("R12 drive low after reset", rd_drive, 0);
   endtask

   task automatic t_fill();
      logic [DW-1:0] keep;
      for (int i = 0; i < (1 << ADDR_W); i++) ctrl_write(i[ADDR_W-1:0], 16'hA500 + i * 17, 0, 1, '1);
      edge_step(); edge_step();
      read_back("R1 read data after one edge", 3);
      chk("R1 drive while selected", rd_drive, 1);
      keep = rd_data;
      ctrl_write(5, 16'h5A5A, 0, 1, '1);
      edge_step();
      chk("R4 controller write launches no read", rd_data, keep);
      read_back("R4 controller write landed", 5);
   endtask

   task automatic t_hush();
      idle(); ctrl_strb_n = 0; sel1 = 0;
      edge_step(); idle();
      chk("R9 drive low after deselect", rd_drive, 0);
      ctrl_read(7);
      chk("R8 dark after reselect edge", rd_drive, 0);
      edge_step();
      chk("R8 dark on first data cycle", rd_drive, 0);
      chk("R1 data present under hush", rd_data, ref_mem[7]);
      edge_step();
      chk("R8 drive after hush", rd_drive, 1);
   endtask

   task automatic t_consec();
      idle(); ctrl_strb_n = 0; addr = 1; edge_step();
      addr = 2; edge_step();
      chk("R7 first of burst", rd_data, ref_mem[1]);
      addr = 4; edge_step();
      chk("R7 second of burst", rd_data, ref_mem[2]);
      idle(); edge_step();
      chk("R7 third of burst", rd_data, ref_mem[4]);
   endtask

   task automatic t_gate();
      idle(); sel0_n = 1; host_strb_n = 0;
      edge_step(); edge_step();
      chk("R2 gated strobe keeps data", rd_data, ref_mem[4]);
      chk("R2 gated strobe keeps drive", rd_drive, 1);
      idle(); host_strb_n = 0; sel1 = 0;
      edge_step(); idle();
      chk("R9 processor-strobe deselect", rd_drive, 0);
   endtask

   task automatic t_host();
      logic [DW-1:0] r;
      host_access(9, 16'hDEAD, 1, 1, '1, r);
      edge_step(); edge_step();
      read_back("R3 write controls on strobe edge ignored", 9);
      host_access(10, 16'h1234, 0, 1, '1, r);
      read_back("R3 second-edge write", 10);
      host_access(11, 16'hBEEF, 1, 0, 2'b10, r);
      read_back("R6 low lane only", 11);
      ctrl_write(12, 16'hC0DE, 1, 0, 2'b01);
      read_back("R6 high lane only", 12);
      ctrl_write(13, 16'h7788, 0, 0, 2'b01);
      read_back("R5 write-all overrides lanes", 13);
   endtask

   task automatic t_oe();
      out_en_n = 1; #1;
      chk("R10 output enable high darkens", rd_drive, 0);
      out_en_n = 0; #1;
      chk("R10 output enable low restores", rd_drive, 1);
   endtask

   task automatic t_adv();
      ctrl_read(14);
      step_n = 0; edge_step();
      chk("R11 base word", rd_data, ref_mem[14]);
      step_n = 0; edge_step();
      chk("R11 advanced word", rd_data, ref_mem[15]);
      step_n = 1; edge_step();
      chk("R11 wrap to zero", rd_data, ref_mem[0]);
   endtask

   initial begin
      #4000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(); addr = '0; wdata = '0; out_en_n = 0;
      for (int i = 0; i < (1 << ADDR_W); i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      edge_step();
      t_fill();
      t_hush();
      t_consec();
      t_gate();
      t_host();
      t_oe();
      t_adv();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule